// File: doc/BRIEF.md
# Quadrature DDS Clock Synthesizer

The block is a direct digital synthesizer that runs from a single system clock. A tuning word sets the output frequency. On every clock the active tuning word is added to a wide phase accumulator. The upper accumulator bits address a quarter-wave sine table, and that one table yields both an 8-bit sine sample and an 8-bit cosine sample. The pair can feed a DAC, or an I/Q modulator that shifts a high-frequency carrier by a digitally controlled offset.

For uses that have no DAC, the most significant accumulator bit is brought out as a square clock. A binary divider chain follows it and divides by a selectable power of two, which reaches very low output frequencies.

Two paths can disturb the phase before the table lookup. The first is a slow second accumulator, read through the same table, whose sine output is scaled by a gain and adds controlled sinusoidal jitter. The second is a plain phase offset input, which accepts dither or a spread profile from outside.

A new tuning word is held in a shadow register and is only applied when a commit strobe is given. The running phase is therefore never disturbed by a half-written value.

Top module: `dds_iq_synth`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the main accumulator, the jitter accumulator, the shadow word and the active word. From the following edge, `sin_out` reads 0, `cos_out` reads 127 and `clk_out` reads 0.
- R2: On every clock the 30-bit main accumulator advances by the active tuning word, wrapping modulo 2^30. A word of 2^30 − k therefore steps the phase backwards by k.
- R3: When `tune_load` is high at an edge, `tune_word` enters the shadow register and nothing else changes. When `tune_commit` is high at an edge, the value the shadow register held before that edge becomes the active word. When load and commit are high at the same edge, the previous shadow value is committed.
- R4: The table holds 256 seven-bit magnitudes. Entry i is round(127·sin(π·(2i+1)/1024)).
- R5: A 10-bit address a is turned into a sample as follows. The index is a[7:0], inverted bitwise when a[8]=1. The magnitude is then negated (two's complement, 8 bits) when a[9]=1. The cosine uses address a+256 modulo 1024.
- R6: The lookup phase is a 16-bit register. At each edge it loads the top 16 accumulator bits plus the jitter offset plus `phase_ofs`, modulo 2^16. At the next edge the table registers the sine and cosine samples for the register's top 10 bits, and these appear on the outputs.
- R7: On every clock the 16-bit jitter accumulator advances by `jit_step`. Its top 10 bits are looked up as in R5 into a registered signed sample j. While `jit_en` is high, the phase offset is (j·`jit_gain`) modulo 2^16, with `jit_gain` unsigned. While `jit_en` is low, the offset is 0.
- R8: `phase_ofs` is added unsigned to the lookup phase modulo 2^16. For example, 16'h4000 advances both outputs by a quarter turn.
- R9: With `div_sel`=0, `clk_out` equals the current accumulator MSB.
- R10: A 31-bit counter increments at the edge after the one at which the accumulator MSB rose. With `div_sel`=k>0, `clk_out` is counter bit k−1, so the MSB clock is divided by 2^k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 30 | Frequency tuning word for the shadow register |
| tune_load | input | 1 | Writes tune_word into the shadow register |
| tune_commit | input | 1 | Moves the shadow word to the active word |
| jit_en | input | 1 | Enables sinusoidal phase jitter |
| jit_step | input | 16 | Jitter accumulator increment |
| jit_gain | input | 8 | Unsigned jitter amplitude |
| phase_ofs | input | 16 | External phase offset for dither or spread |
| div_sel | input | 5 | Divider select, divide by 2^div_sel |
| sin_out | output | 8 | Signed sine sample |
| cos_out | output | 8 | Signed cosine sample |
| clk_out | output | 1 | Square clock, MSB or divided |

## Verification
The tuning word is tried in several forms:
- A step of 2^20 walks every table address in order, which exposes any wrong entry or quadrant fold.
- A quarter-turn step separates the sine lane from the cosine lane.
- A step just below 2^30 drives the phase backwards through the wrap.

A word loaded but not committed, and a load and commit at the same edge, show whether the shadow register isolates the running phase. The static offsets 16'h4000 and 16'hC000 show the external offset separately from the jitter path. Two jitter gains show that the scaled slow sinusoid, and nothing else, is added. A fast MSB clock under divider selects 0, 1, 3 and 31 shows the pass-through and the counter-bit timing.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;
    // Quarter-wave magnitude for entry i of a table of the given depth.
    // Samples sit at half-step positions, so the folded wave is symmetric.
    function automatic int qwave_entry(int i, int depth, int mag_w);
        real full;
        real x;
        full = real'((1 << mag_w) - 1);
        x = full * $sin(3.141592653589793 * (2.0 * real'(i) + 1.0) / (4.0 * real'(depth)));
        return $rtoi(x + 0.5);
    endfunction
endpackage

// File: rtl/dds_qrom.sv
`timescale 1ns/1ps
module dds_qrom #(
    parameter int ADDR_W = 10,
    parameter int SMP_W  = 8,
    parameter int NPORT  = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NPORT-1:0][ADDR_W-1:0]      addr,
    input  logic [NPORT-1:0][ADDR_W-1:0]      rst_addr,
    output logic [NPORT-1:0][SMP_W-1:0]       smp
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int DEPTH = 1 << IDX_W;
    localparam int MAG_W = SMP_W - 1;

    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic             neg;
    } rd_t;

    logic [MAG_W-1:0] tbl [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            tbl[i] = MAG_W'(dds_pkg::qwave_entry(i, DEPTH, MAG_W));
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [ADDR_W-1:0] a_eff;
        logic [IDX_W-1:0]  idx;
        rd_t               rd_d;
        rd_t               rd_q;

        always_comb begin
            a_eff    = rst ? rst_addr[p] : addr[p];
            idx      = a_eff[IDX_W-1:0] ^ {IDX_W{a_eff[ADDR_W-2]}};
            rd_d.mag = tbl[idx];
            rd_d.neg = a_eff[ADDR_W-1];
        end

        always_ff @(posedge clk) begin
            rd_q <= rd_d;
        end

        assign smp[p] = rd_q.neg ? (~{1'b0, rd_q.mag} + 1'b1) : {1'b0, rd_q.mag};
    end
endmodule

// File: rtl/dds_phase_gen.sv
`timescale 1ns/1ps
module dds_phase_gen #(
    parameter int ACC_W  = 30,
    parameter int JACC_W = 16,
    parameter int PH_W   = 16,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  tune_word,
    input  logic              tune_load,
    input  logic              tune_commit,
    input  logic [JACC_W-1:0] jit_step,
    output logic [PH_W-1:0]   phase,
    output logic [ADDR_W-1:0] jit_addr,
    output logic              msb
);
    typedef struct packed {
        logic [ACC_W-1:0]  shadow;
        logic [ACC_W-1:0]  active;
        logic [ACC_W-1:0]  acc;
        logic [JACC_W-1:0] jacc;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d = st_q;
        if (tune_load)   st_d.shadow = tune_word;
        if (tune_commit) st_d.active = st_q.shadow;
        st_d.acc  = st_q.acc + st_q.active;
        st_d.jacc = st_q.jacc + jit_step;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase    = st_q.acc[ACC_W-1 -: PH_W];
    assign jit_addr = st_q.jacc[JACC_W-1 -: ADDR_W];
    assign msb      = st_q.acc[ACC_W-1];

    // R2: accumulator advances by the word that was active one cycle earlier
    a_r2_acc_step: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (st_q.acc == $past(st_q.acc) + $past(st_q.active)));

    // R3: active word only moves on a commit strobe
    a_r3_hold_active: assert property (@(posedge clk) disable iff (rst)
        !tune_commit |=> $stable(st_q.active));

    // R3: committed value is the shadow content from before the strobe edge
    a_r3_commit_shadow: assert property (@(posedge clk) disable iff (rst)
        tune_commit |=> (st_q.active == $past(st_q.shadow)));
endmodule

// File: rtl/dds_clk_div.sv
`timescale 1ns/1ps
module dds_clk_div #(
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             msb,
    input  logic [SEL_W-1:0] div_sel,
    output logic             clk_out
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t              st_d;
    st_t              st_q;
    logic [CNT_W:0]   taps;

    always_comb begin
        st_d      = st_q;
        st_d.prev = msb;
        if (msb && !st_q.prev) st_d.cnt = st_q.cnt + 1'b1;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // tap 0 is the undivided MSB, tap k is counter bit k-1
    assign taps    = {st_q.cnt, msb};
    assign clk_out = taps[div_sel];

    // R10: the counter never jumps by more than one
    a_r10_step_one: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> ((st_q.cnt == $past(st_q.cnt)) || (st_q.cnt == $past(st_q.cnt) + 1'b1)));

    // R10: every MSB rising edge is counted at the following clock
    a_r10_rise_counted: assert property (@(posedge clk) disable iff (rst)
        (msb && !st_q.prev) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
endmodule

// File: rtl/dds_iq_synth.sv
`timescale 1ns/1ps
module dds_iq_synth #(
    parameter int ACC_W  = 30,
    parameter int PH_W   = 16,
    parameter int ADDR_W = 10,
    parameter int SMP_W  = 8,
    parameter int JACC_W = 16,
    parameter int AMP_W  = 8,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  tune_word,
    input  logic              tune_load,
    input  logic              tune_commit,
    input  logic              jit_en,
    input  logic [JACC_W-1:0] jit_step,
    input  logic [AMP_W-1:0]  jit_gain,
    input  logic [PH_W-1:0]   phase_ofs,
    input  logic [SEL_W-1:0]  div_sel,
    output logic [SMP_W-1:0]  sin_out,
    output logic [SMP_W-1:0]  cos_out,
    output logic              clk_out
);
    localparam int PROD_W  = SMP_W + AMP_W + 1;
    localparam int NPORT   = 3;
    localparam logic [ADDR_W-1:0] QTURN = ADDR_W'(1 << (ADDR_W - 2));

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } st_t;

    st_t                           st_d;
    st_t                           st_q;
    logic [PH_W-1:0]               acc_phase;
    logic [ADDR_W-1:0]             jit_addr;
    logic                          acc_msb;
    logic signed [PROD_W-1:0]      prod;
    logic [PH_W-1:0]               jit_ofs;
    logic [NPORT-1:0][ADDR_W-1:0]  rom_addr;
    logic [NPORT-1:0][ADDR_W-1:0]  rom_rst_addr;
    logic [NPORT-1:0][SMP_W-1:0]   rom_smp;

    dds_phase_gen #(
        .ACC_W(ACC_W), .JACC_W(JACC_W), .PH_W(PH_W), .ADDR_W(ADDR_W)
    ) u_phase (
        .clk(clk), .rst(rst),
        .tune_word(tune_word), .tune_load(tune_load), .tune_commit(tune_commit),
        .jit_step(jit_step),
        .phase(acc_phase), .jit_addr(jit_addr), .msb(acc_msb)
    );

    always_comb begin
        prod    = $signed(rom_smp[2]) * $signed({1'b0, jit_gain});
        jit_ofs = jit_en ? PH_W'(prod) : '0;
        st_d.ph = acc_phase + jit_ofs + phase_ofs;
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // port 0 sine, port 1 cosine (quarter turn ahead), port 2 jitter source
    assign rom_addr[0]     = st_q.ph[PH_W-1 -: ADDR_W];
    assign rom_addr[1]     = st_q.ph[PH_W-1 -: ADDR_W] + QTURN;
    assign rom_addr[2]     = jit_addr;
    assign rom_rst_addr[0] = '0;
    assign rom_rst_addr[1] = QTURN;
    assign rom_rst_addr[2] = '0;

    dds_qrom #(
        .ADDR_W(ADDR_W), .SMP_W(SMP_W), .NPORT(NPORT)
    ) u_rom (
        .clk(clk), .rst(rst),
        .addr(rom_addr), .rst_addr(rom_rst_addr), .smp(rom_smp)
    );

    assign sin_out = rom_smp[0];
    assign cos_out = rom_smp[1];

    dds_clk_div #(
        .SEL_W(SEL_W)
    ) u_div (
        .clk(clk), .rst(rst), .msb(acc_msb), .div_sel(div_sel), .clk_out(clk_out)
    );

    // R1: the edge after a reset edge shows the phase-zero samples and a low clock
    a_r1_reset_outputs: assert property (@(posedge clk)
        rst |=> (sin_out == '0 && clk_out == 1'b0 &&
                 cos_out == {1'b0, {(SMP_W-1){1'b1}}}));
endmodule

// File: tb/tb_dds_iq_synth.sv
`timescale 1ns/1ps
module tb_dds_iq_synth;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [29:0] tune_word = '0;
    logic        tune_load = 1'b0;
    logic        tune_commit = 1'b0;
    logic        jit_en = 1'b0;
    logic [15:0] jit_step = '0;
    logic [7:0]  jit_gain = '0;
    logic [15:0] phase_ofs = '0;
    logic [4:0]  div_sel = '0;
    logic [7:0]  sin_out;
    logic [7:0]  cos_out;
    logic        clk_out;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    dds_iq_synth dut (
        .clk(clk), .rst(rst),
        .tune_word(tune_word), .tune_load(tune_load), .tune_commit(tune_commit),
        .jit_en(jit_en), .jit_step(jit_step), .jit_gain(jit_gain),
        .phase_ofs(phase_ofs), .div_sel(div_sel),
        .sin_out(sin_out), .cos_out(cos_out), .clk_out(clk_out)
    );

    // R4 table entry
    function automatic int qs(int i);
        return $rtoi(127.0 * $sin(3.141592653589793 * (2.0 * real'(i) + 1.0) / 1024.0) + 0.5);
    endfunction

    // R5 quadrant fold
    function automatic logic [7:0] lk(logic [9:0] a);
        logic [7:0] idx;
        int m;
        idx = a[8] ? ~a[7:0] : a[7:0];
        m = qs(int'(idx));
        return a[9] ? 8'(-m) : 8'(m);
    endfunction

    // reference state, advanced from the requirements at each edge
    logic [29:0] m_shadow, m_act, m_acc;
    logic [15:0] m_jacc, m_ph;
    logic [7:0]  m_js, m_sin, m_cos;
    logic        m_prev;
    logic [30:0] m_cnt;

    logic [16:0] exp_q[$];
    string       req_q[$];

    always @(posedge clk) begin
        logic [29:0] n_shadow, n_act, n_acc;
        logic [15:0] n_jacc, n_ph, off;
        logic [7:0]  n_js, n_sin, n_cos;
        logic        n_prev;
        logic [30:0] n_cnt;
        logic [31:0] taps;
        if (rst) begin
            n_shadow = '0; n_act = '0; n_acc = '0; n_jacc = '0; n_ph = '0;
            n_js = lk(10'd0); n_sin = lk(10'd0); n_cos = lk(10'd256);
            n_prev = 1'b0; n_cnt = '0;
        end else begin
            n_shadow = tune_load ? tune_word : m_shadow;
            n_act    = tune_commit ? m_shadow : m_act;
            n_acc    = m_acc + m_act;
            n_jacc   = m_jacc + jit_step;
            n_js     = lk(m_jacc[15:6]);
            off      = jit_en ? 16'(int'($signed(m_js)) * int'(jit_gain)) : 16'd0;
            n_ph     = m_acc[29:14] + off + phase_ofs;
            n_sin    = lk(m_ph[15:6]);
            n_cos    = lk(m_ph[15:6] + 10'd256);
            n_prev   = m_acc[29];
            n_cnt    = m_cnt + 31'(m_acc[29] & ~m_prev);
        end
        m_shadow = n_shadow; m_act = n_act; m_acc = n_acc; m_jacc = n_jacc;
        m_js = n_js; m_ph = n_ph; m_sin = n_sin; m_cos = n_cos;
        m_prev = n_prev; m_cnt = n_cnt;
        taps = {m_cnt, m_acc[29]};
        exp_q.push_back({m_sin, m_cos, taps[div_sel]});
        req_q.push_back(cur_req);
    end

    // scoreboard monitor, samples 1 ns after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [16:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                checks++;
                if ({sin_out, cos_out, clk_out} !== e) begin
                    errors++;
                    $display("FAIL %s: sin=%0d cos=%0d clk=%0b expected sin=%0d cos=%0d clk=%0b",
                             r, $signed(sin_out), $signed(cos_out), clk_out,
                             $signed(e[16:9]), $signed(e[8:1]), e[0]);
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_word(logic [29:0] w);
        @(negedge clk);
        tune_word = w; tune_load = 1'b1;
        @(negedge clk);
        tune_load = 1'b0; tune_commit = 1'b1;
        @(negedge clk);
        tune_commit = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        cyc(4);
        chk("R1 sin", int'($signed(sin_out)), 0);
        chk("R1 cos", int'($signed(cos_out)), 127);
        chk("R1 clk", int'(clk_out), 0);
        rst = 1'b0;

        // R3: a loaded but uncommitted word leaves the phase still
        cur_req = "R3";
        tune_word = 30'h0123456; tune_load = 1'b1;
        @(negedge clk);
        tune_load = 1'b0;
        cyc(8);
        chk("R3 sin held", int'($signed(sin_out)), 0);
        chk("R3 cos held", int'($signed(cos_out)), 127);
        tune_commit = 1'b1;
        @(negedge clk);
        tune_commit = 1'b0;

        // R2: plain running
        cur_req = "R2";
        cyc(200);

        // R6: quarter turn per clock shows pipeline alignment
        cur_req = "R6";
        set_word(30'h1000_0000);
        cyc(40);

        // R8: static offsets
        cur_req = "R8";
        set_word(30'h0000_4000);
        phase_ofs = 16'h4000; cyc(60);
        phase_ofs = 16'hC000; cyc(40);
        phase_ofs = 16'h0000;

        // R7: sinusoidal jitter at two gains, then off
        cur_req = "R7";
        jit_step = 16'h0400; jit_gain = 8'd100; jit_en = 1'b1; cyc(300);
        jit_gain = 8'd255; cyc(100);
        jit_en = 1'b0; cyc(30);

        // R4 R5: one table address per clock over the whole wave
        cur_req = "R4,R5";
        set_word(30'h0010_0000);
        cyc(1100);

        // R2: backward step through the wrap
        cur_req = "R2";
        set_word(30'h3FF0_0000);
        cyc(200);

        // R3: load and commit at the same edge take the old shadow
        cur_req = "R3";
        @(negedge clk);
        tune_word = 30'h0000_0001; tune_load = 1'b1; tune_commit = 1'b1;
        @(negedge clk);
        tune_load = 1'b0; tune_commit = 1'b0;
        cyc(50);

        // R9: undivided MSB clock
        cur_req = "R9";
        set_word(30'h0800_0000);
        div_sel = 5'd0; cyc(100);

        // R10: divided clocks
        cur_req = "R10";
        div_sel = 5'd3;  cyc(300);
        div_sel = 5'd1;  cyc(100);
        div_sel = 5'd31; cyc(20);

        // R1: reset in mid-run
        cur_req = "R1";
        rst = 1'b1; cyc(3);
        chk("R1 sin again", int'($signed(sin_out)), 0);
        chk("R1 cos again", int'($signed(cos_out)), 127);
        rst = 1'b0; cyc(5);

        done = 1;
        summary();
        $finish;
    end
endmodule